// File: doc/BRIEF.md
# Shift-Based Approximate Divider

This block produces the coarse-tuning control value for a digitally controlled oscillator. It takes a measured reference period and divides it by an integer ratio. It uses no hardware divider. When the ratio is a power of two, the quotient is the period shifted right by the ratio's exponent.

For any other ratio, the block brackets the ratio between the powers of two just below and just above it. It shifts the period right by each of the two exponents and takes the truncated mean of the two results. For example, a period of 36 with a ratio of 6 gives shifts by 2 and 3, which yield 9 and 4. Their mean, rounded down, is 6.

The inputs are captured into a register stage. The result appears in an output register one clock later, together with a valid strobe and a flag for a zero ratio. A new operand pair may be presented on every clock.

Top module: `shift_avg_divider`

## Requirements
- R1: While reset is asserted and just after its release, `out_valid`, `quot_out` and `ratio_err` are all 0.
- R2: Operands are taken on a rising clock edge where `in_valid` is 1. `out_valid` is 1 for exactly one cycle, after the second rising edge counted from that capture edge. One result is produced per accepted operand pair, back to back.
- R3: When `ratio_in` has exactly one bit set, at position k, `quot_out` equals `period_in` shifted right by k.
- R4: For any other nonzero `ratio_in`, let k be the index of its highest set bit. Then `quot_out` = ((`period_in` >> k) + (`period_in` >> (k+1))) >> 1. The sum is formed one bit wider than the period and then truncated.
- R5: When `ratio_in` is 1, `quot_out` equals `period_in` unchanged.
- R6: When `ratio_in` is 0, `ratio_err` is 1 and `quot_out` is 0.
- R7: In every cycle where `out_valid` is 0, `quot_out` and `ratio_err` keep their previous values. Inputs presented with `in_valid` at 0 are not taken.
- R8: For every nonzero `ratio_in`, `ratio_err` is 0 with the result, and `quot_out` never exceeds `period_in`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair present this cycle |
| period_in | input | TW (16) | Measured period to be divided |
| ratio_in | input | MW (8) | Division ratio |
| out_valid | output | 1 | Result strobe, one cycle per accepted pair |
| quot_out | output | TW (16) | Approximate quotient |
| ratio_err | output | 1 | Set with the result when the ratio was zero |

## Verification
The bound checker follows the operands through its own two-stage copy. On every cycle it checks the following:
- the strobe timing;
- the zero-ratio flag and the zeroed quotient;
- the clear flag for a nonzero ratio;
- the pass-through for a ratio of 1;
- the bound of the quotient by the period;
- the hold of the outputs between results.

The exact shift amounts, the choice of the highest set bit and the truncation of the mean depend on arithmetic. Only the bench's reference function shows these. It is applied to directed corner ratios (0, 1, single powers of two, 3, 6, 255) and to a seeded random back-to-back stream.

// File: rtl/shift_div_pkg.sv
package shift_div_pkg;

  // How the quotient is formed for the latched ratio
  typedef enum logic [1:0] {
    QMODE_ZERO  = 2'd0,
    QMODE_EXACT = 2'd1,
    QMODE_AVG   = 2'd2
  } qmode_e;

endpackage

// File: rtl/msb_locator.sv
module msb_locator #(
  parameter int MW = 8,
  localparam int IW = $clog2(MW)
) (
  input  logic [MW-1:0] ratio,
  output logic [IW-1:0] msb_idx,
  output logic          is_zero,
  output logic          is_pow2
);

  // Priority encoder: the last set bit seen in ascending order wins
  always_comb begin
    msb_idx = '0;
    for (int i = 0; i < MW; i++) begin
      if (ratio[i]) begin
        msb_idx = IW'(i);
      end
    end
  end

  assign is_zero = (ratio == '0);
  assign is_pow2 = !is_zero && ((ratio & (ratio - MW'(1))) == '0);

endmodule

// File: rtl/shift_avg_core.sv
module shift_avg_core
  import shift_div_pkg::*;
#(
  parameter int TW = 16,
  parameter int MW = 8,
  localparam int IW = $clog2(MW)
) (
  input  logic [TW-1:0] period,
  input  logic [IW-1:0] msb_idx,
  input  qmode_e        qmode,
  output logic [TW-1:0] quot
);

  logic [IW:0]   shift_lo;
  logic [IW:0]   shift_hi;
  logic [TW-1:0] short_shift;
  logic [TW-1:0] long_shift;
  logic [TW:0]   pair_sum;

  assign shift_lo    = {1'b0, msb_idx};
  assign shift_hi    = shift_lo + (IW+1)'(1);
  assign short_shift = period >> shift_lo;
  assign long_shift  = period >> shift_hi;
  assign pair_sum    = {1'b0, short_shift} + {1'b0, long_shift};

  always_comb begin
    case (qmode)
      QMODE_EXACT: quot = short_shift;
      QMODE_AVG:   quot = pair_sum[TW:1];
      default:     quot = '0;
    endcase
  end

endmodule

// File: rtl/shift_avg_divider.sv
module shift_avg_divider
  import shift_div_pkg::*;
#(
  parameter int TW = 16,
  parameter int MW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [TW-1:0] period_in,
  input  logic [MW-1:0] ratio_in,
  output logic          out_valid,
  output logic [TW-1:0] quot_out,
  output logic          ratio_err
);

  localparam int IW = $clog2(MW);

  // Operand stage
  logic          cap_valid_q, cap_valid_d;
  logic [TW-1:0] cap_period_q, cap_period_d;
  logic [MW-1:0] cap_ratio_q, cap_ratio_d;

  // Result stage
  logic          res_valid_d;
  logic [TW-1:0] res_quot_d;
  logic          res_err_d;

  logic [IW-1:0] msb_idx;
  logic          ratio_zero;
  logic          ratio_pow2;
  qmode_e        qmode;
  logic [TW-1:0] core_quot;

  msb_locator #(.MW(MW)) i_msb_locator (
    .ratio   (cap_ratio_q),
    .msb_idx (msb_idx),
    .is_zero (ratio_zero),
    .is_pow2 (ratio_pow2)
  );

  always_comb begin
    if (ratio_zero)      qmode = QMODE_ZERO;
    else if (ratio_pow2) qmode = QMODE_EXACT;
    else                 qmode = QMODE_AVG;
  end

  shift_avg_core #(.TW(TW), .MW(MW)) i_shift_avg_core (
    .period  (cap_period_q),
    .msb_idx (msb_idx),
    .qmode   (qmode),
    .quot    (core_quot)
  );

  // Next-state logic
  always_comb begin
    cap_valid_d  = in_valid;
    cap_period_d = cap_period_q;
    cap_ratio_d  = cap_ratio_q;
    if (in_valid) begin
      cap_period_d = period_in;
      cap_ratio_d  = ratio_in;
    end
    res_valid_d = cap_valid_q;
    res_quot_d  = quot_out;
    res_err_d   = ratio_err;
    if (cap_valid_q) begin
      res_quot_d = core_quot;
      res_err_d  = ratio_zero;
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_valid_q  <= 1'b0;
      cap_period_q <= '0;
      cap_ratio_q  <= '0;
      out_valid    <= 1'b0;
      quot_out     <= '0;
      ratio_err    <= 1'b0;
    end else begin
      cap_valid_q  <= cap_valid_d;
      cap_period_q <= cap_period_d;
      cap_ratio_q  <= cap_ratio_d;
      out_valid    <= res_valid_d;
      quot_out     <= res_quot_d;
      ratio_err    <= res_err_d;
    end
  end

endmodule

// File: rtl/shift_avg_divider_chk.sv
module shift_avg_divider_chk #(
  parameter int TW = 16,
  parameter int MW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [TW-1:0] period_in,
  input logic [MW-1:0] ratio_in,
  input logic          out_valid,
  input logic [TW-1:0] quot_out,
  input logic          ratio_err
);

  // Independent two-deep copy of the operand stream
  logic          v1, v2;
  logic [TW-1:0] p1, p2;
  logic [MW-1:0] r1, r2;
  logic [1:0]    age;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1 <= 1'b0; v2 <= 1'b0;
      p1 <= '0;   p2 <= '0;
      r1 <= '0;   r2 <= '0;
      age <= '0;
    end else begin
      v1 <= in_valid; v2 <= v1;
      p1 <= period_in; p2 <= p1;
      r1 <= ratio_in;  r2 <= r1;
      if (age != 2'd2) age <= age + 2'd1;
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd0) |-> (!out_valid && !ratio_err && quot_out == '0)); // R1

  AST_STROBE_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd2) |-> (out_valid == v2)); // R2

  AST_UNIT_RATIO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && v2 && r2 == MW'(1)) |-> (quot_out == p2)); // R5

  AST_ZERO_RATIO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && v2 && r2 == '0) |-> (ratio_err && quot_out == '0)); // R6

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd2 && !out_valid) |-> ($stable(quot_out) && $stable(ratio_err))); // R7

  AST_NONZERO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && v2 && r2 != '0) |-> (!ratio_err && quot_out <= p2)); // R8

endmodule

bind shift_avg_divider shift_avg_divider_chk #(.TW(TW), .MW(MW)) i_shift_avg_divider_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .period_in (period_in),
  .ratio_in  (ratio_in),
  .out_valid (out_valid),
  .quot_out  (quot_out),
  .ratio_err (ratio_err)
);

// File: tb/test_shift_avg_divider.sv
module test_shift_avg_divider;

  localparam int TW = 16;
  localparam int MW = 8;
  localparam int NB = 24;

  logic          clk;
  logic          rst_n;
  logic          in_valid;
  logic [TW-1:0] period_in;
  logic [MW-1:0] ratio_in;
  logic          out_valid;
  logic [TW-1:0] quot_out;
  logic          ratio_err;

  int checks = 0;
  int errors = 0;

  shift_avg_divider #(.TW(TW), .MW(MW)) i_shift_avg_divider (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .period_in(period_in),
    .ratio_in(ratio_in), .out_valid(out_valid), .quot_out(quot_out),
    .ratio_err(ratio_err)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Reference built from the requirement text
  function automatic logic [TW-1:0] ref_quot(logic [TW-1:0] tr, logic [MW-1:0] m);
    int k;
    int ones;
    logic [TW:0] s;
    if (m == '0) return '0;
    k = 0; ones = 0;
    for (int i = 0; i < MW; i++) begin
      if (m[i]) begin k = i; ones++; end
    end
    if (ones == 1) return tr >> k;
    s = {1'b0, tr >> k} + {1'b0, tr >> (k + 1)};
    return s[TW:1];
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Single pair with an idle gap, then a hold check
  task automatic single(input logic [TW-1:0] tr, input logic [MW-1:0] m, input string req);
    logic [TW-1:0] held;
    @(negedge clk);
    in_valid = 1'b1; period_in = tr; ratio_in = m;
    @(negedge clk);
    in_valid = 1'b0; period_in = TW'($urandom); ratio_in = MW'($urandom);
    check(out_valid == 1'b0, "R2 early strobe", 32'(out_valid), 0);
    @(negedge clk);
    check(out_valid == 1'b1, "R2 strobe", 32'(out_valid), 1);
    check(quot_out == ref_quot(tr, m), req, 32'(quot_out), 32'(ref_quot(tr, m)));
    check(ratio_err == (m == '0), "R6/R8 ratio_err", 32'(ratio_err), 32'(m == '0));
    held = quot_out;
    @(negedge clk);
    check(out_valid == 1'b0 && quot_out == held, "R7 hold", 32'(quot_out), 32'(held));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [TW-1:0] bp [NB];
    logic [MW-1:0] bm [NB];
    void'($urandom(32'd2024));
    rst_n = 1'b0; in_valid = 1'b0; period_in = '0; ratio_in = '0;
    repeat (3) @(negedge clk);
    check(!out_valid && quot_out == '0 && !ratio_err, "R1 reset", 32'(quot_out), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid && quot_out == '0 && !ratio_err, "R1 after release", 32'(quot_out), 0);

    single(16'd36,   8'd6,   "R4 m=6");
    single(16'hFFFF, 8'd3,   "R4 m=3");
    single(16'hFFFF, 8'd255, "R4 m=255");
    single(16'hFFFF, 8'd128, "R3 m=128");
    single(16'd1000, 8'd16,  "R3 m=16");
    single(16'hBEEF, 8'd1,   "R5 m=1");
    single(16'h1234, 8'd0,   "R6 m=0");
    single(16'd0,    8'd7,   "R4 zero period");

    // Back-to-back random stream
    for (int i = 0; i < NB + 2; i++) begin
      @(negedge clk);
      if (i >= 2) begin
        check(out_valid == 1'b1, "R2 pipelined strobe", 32'(out_valid), 1);
        check(quot_out == ref_quot(bp[i-2], bm[i-2]), "R3/R4 random",
              32'(quot_out), 32'(ref_quot(bp[i-2], bm[i-2])));
        check(ratio_err == (bm[i-2] == '0), "R8 random flag", 32'(ratio_err), 32'(bm[i-2] == '0));
      end
      if (i < NB) begin
        bp[i] = TW'($urandom);
        bm[i] = (i % 5 == 0) ? (MW'(1) << ($urandom % MW)) : MW'($urandom);
        in_valid = 1'b1; period_in = bp[i]; ratio_in = bm[i];
      end else begin
        in_valid = 1'b0;
      end
    end
    @(negedge clk);
    check(out_valid == 1'b0, "R7 idle after stream", 32'(out_valid), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule